// File: doc/BRIEF.md
# Big-Endian Narrow Access Lane Steering Unit

This unit sits between a processor's load/store stage and a data memory that is one 32-bit word wide and has a write enable for each byte. It forms the effective byte address from a base register value plus a sign-extended 16-bit displacement. For a store, it spreads the register's low byte or halfword across the word and raises only the byte enables for the addressed bytes. For a load, it returns the addressed byte or halfword from the memory word, sign- or zero-extended to 32 bits.

Byte numbering is big endian: the lowest address inside a word names its most significant byte. Accesses that break the natural alignment of their size never reach memory. Instead the unit reports them on a fault output, with an error code that tells a load from a store. Request-side outputs are registered one cycle after the request. The load result is registered one cycle after the memory returns its word. Lane information for the load in flight is held inside the unit between those two points.

Top module: `be_lane_unit`

## Requirements
- R1: The effective address is `req_base + sign_extend(req_offset)`. For an aligned access, `mem_addr` is that address with bits 1:0 cleared. For a faulting access, `fault_addr` carries the full effective address.
- R2: All outputs are registered and are zero after reset. A request on cycle N shows on `mem_*` or `fault_*` at the edge that ends cycle N.
- R3: Store and load byte enables follow a big-endian lane map, with `mem_be[3]` covering bits 31:24 and `mem_be[0]` covering bits 7:0. A byte at address offset k (k = ea[1:0]) sets only `mem_be[3-k]`. A halfword at offset 0 gives 4'b1100 and at offset 2 gives 4'b0011. A word gives 4'b1111.
- R4: Store data is replicated across lanes. A byte store drives `{4{data[7:0]}}`, a halfword store drives `{2{data[15:0]}}`, and a word store drives the data unchanged. Load requests drive zero write data.
- R5: A load takes its byte from bits `31-8k:24-8k` of the returned word. It takes its halfword from bits 31:16 (offset 0) or bits 15:0 (offset 2), using the lane map of R3.
- R6: When `req_unsigned` is 0, byte and halfword loads sign-extend to 32 bits. When it is 1, they zero-extend. Word loads return the word unchanged.
- R7: A halfword with ea[0]=1, or a word with ea[1:0]!=0, is misaligned. It gives `mem_en`=0 and `mem_be`=0, and raises `fault_valid` with `fault_code` 4 for a load or 5 for a store.
- R8: The `req_size` encoding is 0 = byte, 1 = halfword, 2 = word. The value 3 behaves exactly as a word.
- R9: `ld_valid` rises exactly one cycle after `mem_rvalid`. `ld_data` is extracted using the offset, size and signedness of the most recent aligned load request.
- R10: Without `req_valid`, the next cycle has `mem_en`=0, `fault_valid`=0 and `mem_be`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store register value |
| mem_rvalid | input | 1 | Memory returns a word this cycle |
| mem_rdata | input | 32 | Returned memory word |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write word |
| fault_valid | output | 1 | Misaligned access reported |
| fault_code | output | 5 | 4 load error, 5 store error |
| fault_addr | output | 32 | Faulting effective address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
A stored load context that holds the wrong offset or signedness shows up in `ld_data` in the cycle right after the memory answers. The mismatch surfaces in the high bytes, the extension bits or the selected lane. A wrong lane map or wrong alignment decision appears in `mem_be` or `fault_valid` one cycle after the request. The bench also keeps a byte-addressed reference and a word memory written only through the unit's enables. Any store that lands in the wrong lane therefore surfaces on the next load that covers that byte, even when the store's own outputs looked plausible.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_N = DATA_W / 8;
    localparam int LANE_W = $clog2(LANE_N);
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    localparam logic [CODE_W-1:0] CODE_LOAD_ADDR  = 5'd4;
    localparam logic [CODE_W-1:0] CODE_STORE_ADDR = 5'd5;
endpackage

// File: rtl/be_lane_agu.sv
module be_lane_agu
    import be_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    input  size_e             size,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFS_W;

    always_comb begin
        ea = base + {{EXT_W{ofs[OFS_W-1]}}, ofs};
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ea[0];
            default: misaligned = |ea[LANE_W-1:0];
        endcase
    end
endmodule

// File: rtl/be_lane_store.sv
module be_lane_store
    import be_lane_pkg::*;
(
    input  logic [LANE_W-1:0] lo,
    input  size_e             size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_N-1:0] be,
    output logic [DATA_W-1:0] wword
);
    for (genvar i = 0; i < LANE_N; i++) begin : g_lane
        localparam logic [LANE_W-1:0] K = LANE_W'(i);
        localparam int HI = DATA_W - 8 * i - 1;
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    be[LANE_N-1-i] = (lo == K);
                    wword[HI -: 8] = wdata[7:0];
                end
                SZ_HALF: begin
                    be[LANE_N-1-i] = (lo[LANE_W-1] == K[LANE_W-1]);
                    wword[HI -: 8] = K[0] ? wdata[7:0] : wdata[15:8];
                end
                default: begin
                    be[LANE_N-1-i] = 1'b1;
                    wword[HI -: 8] = wdata[HI -: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/be_lane_load.sv
module be_lane_load
    import be_lane_pkg::*;
(
    input  logic [LANE_W-1:0] lo,
    input  size_e             size,
    input  logic              uns,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = 8'h00;
        for (int i = 0; i < LANE_N; i++) begin
            if (lo == LANE_W'(i)) byte_sel = rdata[DATA_W-1-8*i -: 8];
        end
        half_sel = lo[LANE_W-1] ? rdata[15:0] : rdata[DATA_W-1 -: 16];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){byte_sel[7] & ~uns}}, byte_sel};
            SZ_HALF: result = {{(DATA_W-16){half_sel[15] & ~uns}}, half_sel};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [31:0]       req_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              fault_valid,
    output logic [4:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              ld_valid,
    output logic [31:0]       ld_data
);
    typedef struct packed {
        logic              mem_en;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_addr;
        logic [LANE_N-1:0] mem_be;
        logic [DATA_W-1:0] mem_wdata;
        logic              fault_valid;
        logic [CODE_W-1:0] fault_code;
        logic [ADDR_W-1:0] fault_addr;
        logic [LANE_W-1:0] ctx_lo;
        size_e             ctx_size;
        logic              ctx_uns;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
    } state_t;

    state_t st_d, st_q;

    size_e             size_in;
    logic [ADDR_W-1:0] ea;
    logic              misal;
    logic [LANE_N-1:0] lane_be;
    logic [DATA_W-1:0] lane_word;
    logic [DATA_W-1:0] ext_word;

    assign size_in = size_e'(req_size);

    be_lane_agu #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_agu (
        .base       (req_base),
        .ofs        (req_offset),
        .size       (size_in),
        .ea         (ea),
        .misaligned (misal)
    );

    be_lane_store u_store (
        .lo    (ea[LANE_W-1:0]),
        .size  (size_in),
        .wdata (req_wdata),
        .be    (lane_be),
        .wword (lane_word)
    );

    be_lane_load u_load (
        .lo     (st_q.ctx_lo),
        .size   (st_q.ctx_size),
        .uns    (st_q.ctx_uns),
        .rdata  (mem_rdata),
        .result (ext_word)
    );

    always_comb begin
        st_d             = st_q;
        st_d.mem_en      = 1'b0;
        st_d.mem_we      = 1'b0;
        st_d.mem_addr    = '0;
        st_d.mem_be      = '0;
        st_d.mem_wdata   = '0;
        st_d.fault_valid = 1'b0;
        st_d.fault_code  = '0;
        st_d.fault_addr  = '0;
        st_d.ld_valid    = 1'b0;
        st_d.ld_data     = '0;
        if (req_valid) begin
            if (misal) begin
                st_d.fault_valid = 1'b1;
                st_d.fault_code  = req_write ? CODE_STORE_ADDR : CODE_LOAD_ADDR;
                st_d.fault_addr  = ea;
            end else begin
                st_d.mem_en   = 1'b1;
                st_d.mem_we   = req_write;
                st_d.mem_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                st_d.mem_be   = lane_be;
                if (req_write) begin
                    st_d.mem_wdata = lane_word;
                end else begin
                    st_d.ctx_lo   = ea[LANE_W-1:0];
                    st_d.ctx_size = size_in;
                    st_d.ctx_uns  = req_unsigned;
                end
            end
        end
        if (mem_rvalid) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ext_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_en      = st_q.mem_en;
    assign mem_we      = st_q.mem_we;
    assign mem_addr    = st_q.mem_addr;
    assign mem_be      = st_q.mem_be;
    assign mem_wdata   = st_q.mem_wdata;
    assign fault_valid = st_q.fault_valid;
    assign fault_code  = st_q.fault_code;
    assign fault_addr  = st_q.fault_addr;
    assign ld_valid    = st_q.ld_valid;
    assign ld_data     = st_q.ld_data;
endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              mem_rvalid,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              fault_valid,
    input logic [4:0]        fault_code,
    input logic              ld_valid
);
    a_r7_fault_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!mem_en && mem_be == 4'b0000));

    a_r7_fault_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code == 5'd4 || fault_code == 5'd5));

    a_r3_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_be == 4'b1000 || mem_be == 4'b0100 || mem_be == 4'b0010 ||
                    mem_be == 4'b0001 || mem_be == 4'b1100 || mem_be == 4'b0011 ||
                    mem_be == 4'b1111));

    a_r1_word_address: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[1:0] == 2'b00));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_en && !fault_valid && mem_be == 4'b0000));

    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> ld_valid);

    a_r9_result_caused: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));
endmodule

bind be_lane_unit be_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .mem_rvalid  (mem_rvalid),
    .mem_en      (mem_en),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .fault_valid (fault_valid),
    .fault_code  (fault_code),
    .ld_valid    (ld_valid)
);

// File: tb/be_lane_unit_bench.sv
`timescale 1ns/1ps
module be_lane_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_base = '0, req_wdata = '0;
    logic [15:0] req_offset = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_en, mem_we, fault_valid, ld_valid;
    logic [31:0] mem_addr, mem_wdata, fault_addr, ld_data;
    logic [3:0]  mem_be;
    logic [4:0]  fault_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0]  bref [64];
    logic [31:0] wmem [16];

    always #2 clk = ~clk;

    be_lane_unit u_be_lane_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .fault_valid(fault_valid),
        .fault_code(fault_code), .fault_addr(fault_addr), .ld_valid(ld_valid),
        .ld_data(ld_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_misal(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return lo[0];
        return lo != 2'b00;
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 4'b1000 >> lo;
        if (sz == 2'd1) return lo[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_rep(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0) return {4{d[7:0]}};
        if (sz == 2'd1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] f_load(input logic [1:0] sz, input bit uns, input logic [5:0] a);
        logic [5:0] a1, a2, a3;
        a1 = a + 6'd1; a2 = a + 6'd2; a3 = a + 6'd3;
        if (sz == 2'd0) return {{24{bref[a][7] & ~uns}}, bref[a]};
        if (sz == 2'd1) return {{16{bref[a][7] & ~uns}}, bref[a], bref[a1]};
        return {bref[a], bref[a1], bref[a2], bref[a3]};
    endfunction

    task automatic ref_store(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        logic [5:0] a1, a2, a3;
        a1 = a + 6'd1; a2 = a + 6'd2; a3 = a + 6'd3;
        if (sz == 2'd0) bref[a] = d[7:0];
        else if (sz == 2'd1) begin bref[a] = d[15:8]; bref[a1] = d[7:0]; end
        else begin bref[a] = d[31:24]; bref[a1] = d[23:16]; bref[a2] = d[15:8]; bref[a3] = d[7:0]; end
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input bit uns,
                          input logic [31:0] ea, input logic [15:0] ofs, input logic [31:0] d);
        bit mis;
        mis = f_misal(sz, ea[1:0]);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
        req_offset = ofs; req_base = ea - {{16{ofs[15]}}, ofs}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (mis) begin
            chk("R7 fault_valid", {31'b0, fault_valid}, 32'd1);
            chk("R7 fault_code", {27'b0, fault_code}, wr ? 32'd5 : 32'd4);
            chk("R1 fault_addr", fault_addr, ea);
            chk("R7 no access", {27'b0, mem_en, mem_be}, 32'd0);
        end else begin
            chk("R7 no fault", {31'b0, fault_valid}, 32'd0);
            chk("R2 mem_en/we", {30'b0, mem_en, mem_we}, {30'b0, 1'b1, wr});
            chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
            chk((sz == 2'd3) ? "R8 wide size be" : "R3 be", {28'b0, mem_be}, {28'b0, f_be(sz, ea[1:0])});
            if (wr) begin
                chk("R4 wdata", mem_wdata, f_rep(sz, d));
                for (int i = 0; i < 4; i++)
                    if (mem_be[3-i]) wmem[mem_addr[5:2]][8*(3-i) +: 8] = mem_wdata[8*(3-i) +: 8];
                ref_store(sz, ea[5:0], d);
            end else begin
                chk("R4 load wdata zero", mem_wdata, 32'd0);
                mem_rvalid = 1'b1;
                mem_rdata = wmem[mem_addr[5:2]];
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata = 32'hDEAD_BEEF;
                chk("R9 ld_valid", {31'b0, ld_valid}, 32'd1);
                chk(uns ? "R5 R6 ld_data zext" : "R5 R6 ld_data sext", ld_data, f_load(sz, uns, ea[5:0]));
                @(negedge clk);
                chk("R9 ld_valid drops", {31'b0, ld_valid}, 32'd0);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        for (int i = 0; i < 64; i++) bref[i] = 8'($urandom);
        for (int i = 0; i < 16; i++) wmem[i] = {bref[4*i], bref[4*i+1], bref[4*i+2], bref[4*i+3]};
        repeat (3) @(negedge clk);
        chk("R2 reset outputs", {mem_en, mem_we, fault_valid, ld_valid, mem_be, 24'b0}, 32'd0);
        chk("R2 reset data", mem_wdata | ld_data | mem_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle", {29'b0, mem_en, fault_valid, ld_valid}, 32'd0);

        for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 4; lo++) begin
                logic [31:0] ea;
                ea = 32'd16 + 32'(lo);
                access(1'b1, 2'(sz), 1'b0, ea, 16'h0004, 32'h8190_A2F3 + 32'(lo));
                access(1'b0, 2'(sz), 1'b0, ea, 16'h0004, 32'h0);
                access(1'b0, 2'(sz), 1'b1, ea, 16'hFFFC, 32'h0);
            end

        access(1'b1, 2'd2, 1'b0, 32'h1000_0024, 16'hFFF0, 32'hCAFE_F00D);
        access(1'b0, 2'd1, 1'b0, 32'h1000_0026, 16'h8000, 32'h0);
        access(1'b0, 2'd0, 1'b1, 32'h1000_0025, 16'h7FFF, 32'h0);
        access(1'b1, 2'd1, 1'b0, 32'h0000_0031, 16'h0001, 32'h1234_5678);
        access(1'b0, 2'd2, 1'b0, 32'h0000_0032, 16'h0002, 32'h0);

        @(negedge clk);
        chk("R10 idle after run", {29'b0, mem_en, fault_valid, ld_valid}, 32'd0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ea;
            logic [1:0] sz;
            ea = 32'h0000_4000 | 32'($urandom_range(0, 63));
            sz = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) begin
                if (sz == 2'd1) ea[0] = 1'b0;
                if (sz[1]) ea[1:0] = 2'b00;
            end
            access(1'($urandom), sz, 1'($urandom), ea, 16'($urandom), $urandom);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule